// File: doc/BRIEF.md
# Multiword Disk DMA Strobe Timing Generator

This block produces the read and write strobes for a DMA data burst on a parallel disk interface. When a transfer starts, it takes the requested transfer mode, the minimum DMA cycle time the drive reports, a mode-setup-failed flag, the transfer direction and a word count. From these it works out a target cycle time. It rounds that target up to one of four fixed strobe timing types. Each type is a number of active ticks and recovery ticks, and one tick is 62.5 ns, built from `TICK_DIV` clock cycles.

The transfer then runs one word at a time. A word starts only while the drive raises its DMA request. During the active phase the strobe for the chosen direction is high. During recovery both strobes are low, and the acknowledge stays high through both phases. The drive may lower its request between words, and the sequence waits for it. A stop request that is seen between words ends the transfer early.

At the end the block gives a one-cycle done pulse. It also reports how many words were left over and raises an error flag when that number is not zero. A start request that arrives while a transfer is still running is refused and flagged.

Top module: `dma_strobe_gen`

## Requirements
- R1: Mode codes are 0-2 for single-word modes 0-2 and 3-5 for multiword modes 0-2. Any code above 5 is handled exactly like code 5.
- R2: Multiword modes 1 and 2 aim at a 250 ns cycle. Multiword mode 0 and every single-word mode aim at 480 ns. The type is reported on `timing_type` as 0=A, 1=B, 2=C, 3=D, so mode 0 gives A and modes 1 and 2 give C.
- R3: For multiword modes 1 and 2 only, a drive minimum longer than the target replaces the target. A shorter drive minimum changes nothing.
- R4: The type chosen is the fastest one whose cycle is at least the target. The cycles are D 187 ns, C 250 ns, B 437 ns and A 562 ns. A target above 562 ns gives A. The type does not change while the block is busy.
- R5: When `setup_fail` is high at start, the target becomes 480 ns whatever the mode.
- R6: The active and recovery phases last the following numbers of ticks, where one tick is `TICK_DIV` clock cycles: A 4+5, B 3+4, C 2+2, D 1+2.
- R7: During the active phase `wr_stb` is high if `dir_write`=1 and `rd_stb` is high if `dir_write`=0. Both strobes are low during recovery and never high together. `dmack` is high through both phases.
- R8: A word's active phase starts only on a clock where `dmarq` is high and the block is waiting between words. Otherwise the block keeps waiting.
- R9: A `start` seen while `busy` is high is ignored, and `start_err` pulses one cycle later.
- R10: `done` is high for exactly one cycle after the last word or after a stop. A `stop` seen between words ends the transfer. `residue` holds the words still left and `residue_err` is 1 when that count is not zero.
- R11: A start with a word count of zero goes straight to the done cycle, with a residue of 0.
- R12: In reset, every strobe, `busy`, `done`, both error flags and `residue` are 0, and `timing_type` is A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the current setup inputs |
| xfer_mode | input | 4 | Requested transfer mode code |
| drive_min_ns | input | NS_W | Minimum DMA cycle time reported by the drive, in ns |
| setup_fail | input | 1 | Drive mode setup failed; use the slow target |
| dir_write | input | 1 | 1 = write (host to drive), 0 = read |
| word_count | input | CNT_W | Number of words to move |
| stop | input | 1 | End the transfer at the next point between words |
| dmarq | input | 1 | Drive DMA request |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| dmack | output | 1 | DMA acknowledge to the drive |
| busy | output | 1 | Transfer in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| start_err | output | 1 | Start refused because the block was busy |
| residue | output | CNT_W | Words left at completion |
| residue_err | output | 1 | Residue is not zero |
| timing_type | output | 2 | Timing type in use |

## Verification
The properties assume that `stop` is held high from the time it is raised until `done`, and that nobody asks for a start during the two cycles that follow reset release. The stimulus changes inputs only at falling edges. It keeps `stop` high until the model returns to idle and waits out the reset synchronizer before the first start. The setup inputs are read only in the start cycle. The bench therefore changes them freely while a transfer runs, to show that this has no effect. `dmarq` follows several on/off patterns so that waits between words occur at different points in the recovery and active timing.

// File: rtl/dma_strobe_pkg.sv
`timescale 1ns/1ps
package dma_strobe_pkg;

  typedef enum logic [1:0] {
    TT_A = 2'd0,
    TT_B = 2'd1,
    TT_C = 2'd2,
    TT_D = 2'd3
  } timing_type_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_ACT  = 3'd2,
    PH_REC  = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  localparam int unsigned NUM_TYPES      = 4;
  localparam int unsigned MAX_TICKS      = 5;
  localparam logic [3:0]  MODE_MW0       = 4'd3;
  localparam logic [3:0]  MODE_MW1       = 4'd4;
  localparam logic [3:0]  MODE_MW2       = 4'd5;
  localparam int unsigned SLOW_TARGET_NS = 480;
  localparam int unsigned FAST_TARGET_NS = 250;

  function automatic int unsigned act_ticks(timing_type_e t);
    case (t)
      TT_A:    return 4;
      TT_B:    return 3;
      TT_C:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned rec_ticks(timing_type_e t);
    case (t)
      TT_A:    return 5;
      TT_B:    return 4;
      default: return 2;
    endcase
  endfunction

  // cycle length in whole ns: ticks * 62.5, rounded down
  function automatic int unsigned cycle_ns(timing_type_e t);
    return ((act_ticks(t) + rec_ticks(t)) * 125) / 2;
  endfunction

  // rank 0 is the fastest type
  function automatic timing_type_e type_by_rank(int unsigned rank);
    case (rank)
      0:       return TT_D;
      1:       return TT_C;
      2:       return TT_B;
      default: return TT_A;
    endcase
  endfunction

endpackage

// File: rtl/dma_mode_resolver.sv
`timescale 1ns/1ps
module dma_mode_resolver
  import dma_strobe_pkg::*;
#(
  parameter int unsigned NS_W = 16
) (
  input  logic [3:0]      mode,
  input  logic [NS_W-1:0] drive_min_ns,
  input  logic            setup_fail,
  output timing_type_e    ttype
);

  logic [3:0]      eff_mode;
  logic            uses_drive;
  logic [NS_W-1:0] base_ns;
  logic [NS_W-1:0] target_ns;
  logic [NUM_TYPES-1:0] fits;

  always_comb begin
    eff_mode   = (mode > MODE_MW2) ? MODE_MW2 : mode;
    uses_drive = (eff_mode == MODE_MW1) || (eff_mode == MODE_MW2);
    base_ns    = uses_drive ? NS_W'(FAST_TARGET_NS) : NS_W'(SLOW_TARGET_NS);
    if (setup_fail)
      target_ns = NS_W'(SLOW_TARGET_NS);
    else if (uses_drive && (drive_min_ns > base_ns))
      target_ns = drive_min_ns;
    else
      target_ns = base_ns;
  end

  // one comparator per timing type
  for (genvar r = 0; r < NUM_TYPES; r++) begin : g_fit
    always_comb fits[r] = (32'(target_ns) <= cycle_ns(type_by_rank(r)));
  end

  // slowest type by default; a faster fitting type overrides
  always_comb begin
    ttype = TT_A;
    for (int r = NUM_TYPES - 1; r >= 0; r--) begin
      if (fits[r]) ttype = type_by_rank(r);
    end
  end

endmodule

// File: rtl/dma_phase_timer.sv
`timescale 1ns/1ps
module dma_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dma_strobe_seq.sv
`timescale 1ns/1ps
module dma_strobe_seq
  import dma_strobe_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TIMER_W  = 4,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_write,
  input  logic [CNT_W-1:0]   word_count,
  input  logic               stop,
  input  logic               dmarq,
  input  timing_type_e       ttype_in,
  input  logic               tmr_zero,
  output logic               tmr_load,
  output logic [TIMER_W-1:0] tmr_val,
  output logic               tmr_run,
  output logic               rd_stb,
  output logic               wr_stb,
  output logic               dmack,
  output logic               busy,
  output logic               done,
  output logic               start_err,
  output logic [CNT_W-1:0]   residue,
  output logic               residue_err,
  output timing_type_e       type_q
);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               dir_q, dir_d;
  timing_type_e       type_d;
  logic [CNT_W-1:0]   res_q, res_d;
  logic               rerr_q, rerr_d;
  logic               serr_q, serr_d;
  logic [TIMER_W-1:0] act_clks, rec_clks;

  always_comb begin
    act_clks = TIMER_W'(act_ticks(type_q) * TICK_DIV - 1);
    rec_clks = TIMER_W'(rec_ticks(type_q) * TICK_DIV - 1);
  end

  always_comb begin
    phase_d  = phase_q;
    left_d   = left_q;
    dir_d    = dir_q;
    type_d   = type_q;
    res_d    = res_q;
    rerr_d   = rerr_q;
    serr_d   = start && (phase_q != PH_IDLE);
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          dir_d   = dir_write;
          type_d  = ttype_in;
          left_d  = word_count;
          res_d   = '0;
          rerr_d  = 1'b0;
          phase_d = (word_count == '0) ? PH_DONE : PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (stop) begin
          phase_d = PH_DONE;
          res_d   = left_q;
          rerr_d  = (left_q != '0);
        end else if (dmarq) begin
          phase_d  = PH_ACT;
          tmr_load = 1'b1;
          tmr_val  = act_clks;
        end
      end
      PH_ACT: begin
        if (tmr_zero) begin
          phase_d  = PH_REC;
          left_d   = left_q - 1'b1;
          tmr_load = 1'b1;
          tmr_val  = rec_clks;
        end
      end
      PH_REC: begin
        if (tmr_zero) phase_d = (left_q == '0) ? PH_DONE : PH_WAIT;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      dir_q   <= 1'b0;
      type_q  <= TT_A;
      res_q   <= '0;
      rerr_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
      dir_q   <= dir_d;
      type_q  <= type_d;
      res_q   <= res_d;
      rerr_q  <= rerr_d;
      serr_q  <= serr_d;
    end
  end

  always_comb begin
    tmr_run     = (phase_q == PH_ACT) || (phase_q == PH_REC);
    rd_stb      = (phase_q == PH_ACT) && !dir_q;
    wr_stb      = (phase_q == PH_ACT) && dir_q;
    dmack       = tmr_run;
    busy        = (phase_q != PH_IDLE);
    done        = (phase_q == PH_DONE);
    start_err   = serr_q;
    residue     = res_q;
    residue_err = rerr_q;
  end

endmodule

// File: rtl/dma_strobe_gen.sv
`timescale 1ns/1ps
module dma_strobe_gen
  import dma_strobe_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NS_W     = 16,
  parameter int unsigned TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       xfer_mode,
  input  logic [NS_W-1:0]  drive_min_ns,
  input  logic             setup_fail,
  input  logic             dir_write,
  input  logic [CNT_W-1:0] word_count,
  input  logic             stop,
  input  logic             dmarq,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             dmack,
  output logic             busy,
  output logic             done,
  output logic             start_err,
  output logic [CNT_W-1:0] residue,
  output logic             residue_err,
  output logic [1:0]       timing_type
);

  localparam int unsigned MAX_CLKS = MAX_TICKS * TICK_DIV;
  localparam int unsigned TIMER_W  = (MAX_CLKS > 2) ? $clog2(MAX_CLKS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  timing_type_e       ttype_sel, ttype_q;
  logic               tmr_load, tmr_run, tmr_zero;
  logic [TIMER_W-1:0] tmr_val;

  dma_mode_resolver #(.NS_W(NS_W)) u_resolve (
    .mode         (xfer_mode),
    .drive_min_ns (drive_min_ns),
    .setup_fail   (setup_fail),
    .ttype        (ttype_sel)
  );

  dma_phase_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .zero     (tmr_zero)
  );

  dma_strobe_seq #(
    .CNT_W    (CNT_W),
    .TIMER_W  (TIMER_W),
    .TICK_DIV (TICK_DIV)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start       (start),
    .dir_write   (dir_write),
    .word_count  (word_count),
    .stop        (stop),
    .dmarq       (dmarq),
    .ttype_in    (ttype_sel),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_run     (tmr_run),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .dmack       (dmack),
    .busy        (busy),
    .done        (done),
    .start_err   (start_err),
    .residue     (residue),
    .residue_err (residue_err),
    .type_q      (ttype_q)
  );

  assign timing_type = ttype_q;

endmodule

// File: rtl/dma_strobe_gen_chk.sv
`timescale 1ns/1ps
module dma_strobe_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             dmarq,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             dmack,
  input logic             busy,
  input logic             done,
  input logic             start_err,
  input logic [CNT_W-1:0] residue,
  input logic             residue_err,
  input logic [1:0]       timing_type
);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R7
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> dmack);

  // R8
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmack) |-> $past(dmarq));

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> start_err);

  // R9
  no_false_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && busy) |=> !start_err);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !dmack));

  // R10
  residue_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (residue_err == (residue != '0)));

  // R4
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(timing_type));

endmodule

bind dma_strobe_gen dma_strobe_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .dmarq       (dmarq),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .dmack       (dmack),
  .busy        (busy),
  .done        (done),
  .start_err   (start_err),
  .residue     (residue),
  .residue_err (residue_err),
  .timing_type (timing_type)
);

// File: tb/dma_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module dma_strobe_gen_tb_top;

  localparam int CNT_W    = 16;
  localparam int NS_W     = 16;
  localparam int TICK_DIV = 2;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [3:0]       xfer_mode;
  logic [NS_W-1:0]  drive_min_ns;
  logic             setup_fail;
  logic             dir_write;
  logic [CNT_W-1:0] word_count;
  logic             stop;
  logic             dmarq;
  logic             rd_stb, wr_stb, dmack, busy, done, start_err, residue_err;
  logic [CNT_W-1:0] residue;
  logic [1:0]       timing_type;

  dma_strobe_gen #(.CNT_W(CNT_W), .NS_W(NS_W), .TICK_DIV(TICK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_mode(xfer_mode),
    .drive_min_ns(drive_min_ns), .setup_fail(setup_fail), .dir_write(dir_write),
    .word_count(word_count), .stop(stop), .dmarq(dmarq),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .dmack(dmack), .busy(busy), .done(done),
    .start_err(start_err), .residue(residue), .residue_err(residue_err),
    .timing_type(timing_type)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 4 ns period

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  int strobe_cycles = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int act_tbl[4] = '{4, 3, 2, 1};
  int rec_tbl[4] = '{5, 4, 2, 2};

  function automatic int ref_type(int mode, int dmin, bit fail);
    int m, tgt;
    m   = (mode > 5) ? 5 : mode;
    tgt = (m == 4 || m == 5) ? ((dmin > 250) ? dmin : 250) : 480;
    if (fail) tgt = 480;
    if (tgt <= 187) return 3;
    if (tgt <= 250) return 2;
    if (tgt <= 437) return 1;
    return 0;
  endfunction

  // m_ph: 0 idle, 1 waiting for request, 2 strobe, 3 recovery, 4 done
  int m_ph, m_left, m_tmr, m_dir, m_type, m_res, m_rerr, m_serr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_tmr = 0; m_dir = 0; m_type = 0;
      m_res = 0; m_rerr = 0; m_serr = 0;
    end else begin
      m_serr = (start && m_ph != 0) ? 1 : 0;
      case (m_ph)
        0: if (start) begin
             m_dir  = dir_write;
             m_type = ref_type(xfer_mode, drive_min_ns, setup_fail);
             m_left = word_count;
             m_res  = 0; m_rerr = 0;
             m_ph   = (word_count == 0) ? 4 : 1;
           end
        1: if (stop) begin
             m_ph = 4; m_res = m_left; m_rerr = (m_left != 0);
           end else if (dmarq) begin
             m_ph = 2; m_tmr = act_tbl[m_type] * TICK_DIV;
           end
        2: begin
             m_tmr--;
             if (m_tmr == 0) begin
               m_left--; m_ph = 3; m_tmr = rec_tbl[m_type] * TICK_DIV;
             end
           end
        3: begin
             m_tmr--;
             if (m_tmr == 0) m_ph = (m_left == 0) ? 4 : 1;
           end
        default: m_ph = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [8:0] a, e;
      a = {rd_stb, wr_stb, dmack, busy, done, start_err, residue_err, timing_type};
      e = {1'(m_ph == 2 && m_dir == 0), 1'(m_ph == 2 && m_dir == 1), 1'(m_ph == 2 || m_ph == 3),
           1'(m_ph != 0), 1'(m_ph == 4), 1'(m_serr), 1'(m_rerr), 2'(m_type)};
      check(a == e, "R6 R7 R8 R9 R10 per-cycle outputs", int'(a), int'(e));
      check(int'(residue) == m_res, "R10 per-cycle residue", int'(residue), m_res);
      if (rd_stb || wr_stb) strobe_cycles++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input int mode, input int dmin, input bit fail, input bit dw,
                      input int cnt, input int pat, input int stop_at, input int busy_at,
                      input int exp_type, input string tag);
    int k;
    @(negedge clk);
    xfer_mode = 4'(mode); drive_min_ns = NS_W'(dmin); setup_fail = fail;
    dir_write = dw; word_count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // setup inputs are sampled only at start: scramble them now
    xfer_mode = 4'd4; drive_min_ns = NS_W'(900); setup_fail = 1'b0;
    dir_write = ~dw; word_count = CNT_W'(77);
    check(int'(timing_type) == exp_type, tag, int'(timing_type), exp_type);
    k = 0;
    while (m_ph != 0) begin
      case (pat)
        0:       dmarq = 1'b1;
        1:       dmarq = (k % 3) != 0;
        default: dmarq = (k % 5) < 2;
      endcase
      if (k == stop_at) stop = 1'b1;
      if (k == busy_at) begin
        start = 1'b1; xfer_mode = 4'd5;
        @(negedge clk);
        start = 1'b0;
        check(start_err == 1'b1, "R9 start while busy flagged", int'(start_err), 1);
        check(int'(timing_type) == exp_type, "R9 refused start leaves type", int'(timing_type), exp_type);
        k++;
      end
      @(negedge clk);
      k++;
    end
    stop = 1'b0; dmarq = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; xfer_mode = '0; drive_min_ns = '0; setup_fail = 1'b0;
    dir_write = 1'b0; word_count = '0; stop = 1'b0; dmarq = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check({rd_stb, wr_stb, dmack, busy, done, start_err, residue_err} == 7'b0,
          "R12 reset outputs", int'({rd_stb, wr_stb, dmack, busy, done, start_err, residue_err}), 0);
    check(residue == '0 && timing_type == 2'd0, "R12 reset residue/type",
          int'({residue, timing_type}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    strobe_cycles = 0;
    xfer(5, 0, 0, 0, 3, 0, -1, -1, 2, "R2 mw2 -> C");
    check(strobe_cycles == 3 * 2 * TICK_DIV, "R6 R7 type C read strobe length",
          strobe_cycles, 3 * 2 * TICK_DIV);
    strobe_cycles = 0;
    xfer(3, 0, 0, 1, 2, 1, -1, -1, 0, "R2 mw0 -> A");
    check(strobe_cycles == 2 * 4 * TICK_DIV, "R6 R7 type A write strobe length",
          strobe_cycles, 2 * 4 * TICK_DIV);
    xfer(1,   0,   0, 0, 1, 0, -1, -1, 0, "R2 single-word -> A");
    xfer(12,  0,   0, 1, 2, 2, -1, -1, 2, "R1 fast code clamped -> C");
    xfer(9,   300, 0, 0, 2, 1, -1, -1, 1, "R1 R3 clamp and stretch -> B");
    xfer(4,   437, 0, 0, 1, 0, -1, -1, 1, "R4 437 fits B");
    xfer(4,   438, 0, 1, 1, 0, -1, -1, 0, "R4 438 needs A");
    xfer(4,   700, 0, 0, 1, 2, -1, -1, 0, "R4 beyond A saturates");
    xfer(5,   200, 0, 0, 2, 0, -1, -1, 2, "R3 shorter drive min ignored");
    xfer(5,   0,   1, 1, 2, 1, -1, -1, 0, "R5 setup fail -> A");
    xfer(5,   0,   0, 0, 6, 2, 12, -1, 2, "R8 R10 stop mid transfer");
    check(residue != '0 && residue_err, "R10 residue after stop", int'(residue), m_res);
    xfer(3,   0,   0, 1, 2, 0, -1, 2, 0, "R9 busy start test");
    xfer(3,   0,   0, 0, 0, 0, -1, -1, 0, "R11 zero count");
    check(residue == '0 && !residue_err, "R11 zero count residue", int'(residue), 0);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule